// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans up a set of slow external input lines before they reach level status and interrupt detection logic. Each line is first brought into the core clock domain through a two-stage synchronizer and then passes through its own filter lane. A lane can pass the line straight through, or require a new level to stay stable for a programmed time before the output follows it. That time is a count multiplied by one of four timer units. The units are measured in pulses of a slow real-time tick, which is supplied as a one-cycle enable in the core clock domain.

Two of the filter modes are asymmetric. In one, low-going pulses reach the output at once and only rising changes are qualified. The other is the mirror image. The remaining modes are full bypass and qualification in both directions.

Each lane is a two-state machine. In `LS_IDLE` the output equals the synchronized input, or the difference has just appeared. In `LS_QUAL` a change is being timed. The transitions are:
- idle-to-qual: the synchronized input differs from the output and the mode filters that direction.
- idle-bypass: the input differs and the mode does not filter that direction; the output is updated and the lane stays in `LS_IDLE`.
- qual-expire: the programmed time has elapsed; the output is updated and the lane returns to idle.
- qual-abort: the input returned to the output level.
- qual-reprogram: the count or unit field changed.
- qual-bypass: the mode stopped filtering the pending direction; the output is updated at once.

Top module: `debounce_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every `debounced` bit is 0.
- R2: Each `pin_raw` bit passes through two synchronizer flops. In a lane that does not filter the change, the output therefore follows a raw change on the third rising clock edge after it.
- R3: A lane whose mode field is 0 passes its synchronized input to the output with no timing, whatever its count and unit.
- R4: The unit field selects the timer unit in `rtc_tick` pulses: 0 selects 2, 1 selects 8, 2 selects 512, 3 selects 2048.
- R5: With mode 3, a change in either direction reaches the output only after the synchronized input has differed from the output for count × unit ticks. With `rtc_tick` held high, the output changes on the (count × unit + 4)th rising edge after the raw change.
- R6: If the synchronized input returns to the output level before the time has elapsed, the change is dropped. A later change is timed again from zero.
- R7: With mode 1, a falling change follows as in R2 and a rising change is qualified as in R5.
- R8: With mode 2, a rising change follows as in R2 and a falling change is qualified as in R5.
- R9: The qualification timer advances only in cycles where `rtc_tick` is 1.
- R10: Changing a lane's count or unit field while a change is being qualified discards the progress made, and timing restarts from zero.
- R11: A count of 0 in a filtering mode gives a latency of four rising edges, one more than bypass.
- R12: Each lane filters independently of the other lanes' inputs and configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle pulse of the slow real-time tick |
| pin_raw | input | NUM_PINS | Unsynchronized input lines |
| cfg_count | input | NUM_PINS*CNT_W | Per-lane count fields, lane i at [i*CNT_W +: CNT_W] |
| cfg_unit | input | NUM_PINS*2 | Per-lane unit select, lane i at [i*2 +: 2] |
| cfg_mode | input | NUM_PINS*2 | Per-lane mode: 0 bypass, 1 keep low pulses, 2 keep high pulses, 3 filter both |
| debounced | output | NUM_PINS | Filtered levels |

## Verification
The bench uses fixed latencies. A raw change that is not filtered appears three rising edges after the change. A qualified change appears count × unit + 4 edges after it, provided the tick is held high. For every case the bench samples on the falling edge one cycle before the due edge, where it expects the old level, and on the falling edge right after it, where it expects the new level. The same method sets the sample points for the reprogramming and tick-stall tests. It also sets them for glitch rejection, where the output must still hold its old level well after the due edge would have been.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

    typedef enum logic [1:0] {
        DBM_OFF       = 2'd0,
        DBM_KEEP_LOW  = 2'd1,
        DBM_KEEP_HIGH = 2'd2,
        DBM_BOTH      = 2'd3
    } dbm_e;

    typedef enum logic {
        LS_IDLE = 1'b0,
        LS_QUAL = 1'b1
    } lane_state_e;

endpackage

// File: rtl/debounce_sync.sv
module debounce_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;
endmodule

// File: rtl/debounce_lane.sv
module debounce_lane
    import debounce_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int UNIT0 = 2,
    parameter int UNIT1 = 8,
    parameter int UNIT2 = 512,
    parameter int UNIT3 = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       unit_sel,
    input  logic [1:0]       mode,
    output logic             level_out
);
    localparam int PRE_W = (UNIT3 > 1) ? $clog2(UNIT3) : 1;

    lane_state_e      state_q, state_d;
    logic             out_q, out_d;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic [CNT_W-1:0] units_q, units_d;
    logic [CNT_W+1:0] cfg_prev_q;

    logic             mismatch;
    logic             filt;
    logic             cfg_changed;
    logic [PRE_W-1:0] unit_last;

    always_comb begin
        unique case (unit_sel)
            2'd0:    unit_last = PRE_W'(UNIT0 - 1);
            2'd1:    unit_last = PRE_W'(UNIT1 - 1);
            2'd2:    unit_last = PRE_W'(UNIT2 - 1);
            default: unit_last = PRE_W'(UNIT3 - 1);
        endcase
    end

    assign mismatch    = (sync_in != out_q);
    assign cfg_changed = ({count, unit_sel} != cfg_prev_q);

    always_comb begin
        unique case (dbm_e'(mode))
            DBM_OFF:       filt = 1'b0;
            DBM_KEEP_LOW:  filt = sync_in;
            DBM_KEEP_HIGH: filt = !sync_in;
            default:       filt = 1'b1;
        endcase
    end

    // next-state and datapath
    always_comb begin
        state_d = state_q;
        out_d   = out_q;
        pre_d   = pre_q;
        units_d = units_q;
        unique case (state_q)
            LS_IDLE: begin
                if (mismatch) begin
                    if (filt) begin
                        state_d = LS_QUAL;
                        pre_d   = '0;
                        units_d = '0;
                    end else begin
                        out_d = sync_in;
                    end
                end
            end
            LS_QUAL: begin
                if (!mismatch) begin
                    state_d = LS_IDLE;
                end else if (!filt) begin
                    out_d   = sync_in;
                    state_d = LS_IDLE;
                end else if (cfg_changed) begin
                    state_d = LS_IDLE;
                end else if (units_q == count) begin
                    out_d   = sync_in;
                    state_d = LS_IDLE;
                end else if (tick) begin
                    if (pre_q == unit_last) begin
                        pre_d   = '0;
                        units_d = units_q + 1'b1;
                    end else begin
                        pre_d = pre_q + 1'b1;
                    end
                end
            end
            default: state_d = LS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= state_d;
    end

    // output and timer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q      <= 1'b0;
            pre_q      <= '0;
            units_q    <= '0;
            cfg_prev_q <= '0;
        end else begin
            out_q      <= out_d;
            pre_q      <= pre_d;
            units_q    <= units_d;
            cfg_prev_q <= {count, unit_sel};
        end
    end

    assign level_out = out_q;
endmodule

// File: rtl/debounce_bank.sv
module debounce_bank #(
    parameter int NUM_PINS = 4,
    parameter int CNT_W    = 4,
    parameter int UNIT0    = 2,
    parameter int UNIT1    = 8,
    parameter int UNIT2    = 512,
    parameter int UNIT3    = 2048
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rtc_tick,
    input  logic [NUM_PINS-1:0]       pin_raw,
    input  logic [NUM_PINS*CNT_W-1:0] cfg_count,
    input  logic [NUM_PINS*2-1:0]     cfg_unit,
    input  logic [NUM_PINS*2-1:0]     cfg_mode,
    output logic [NUM_PINS-1:0]       debounced
);
    logic [NUM_PINS-1:0] pin_sync;

    debounce_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (pin_sync)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
        debounce_lane #(
            .CNT_W (CNT_W),
            .UNIT0 (UNIT0),
            .UNIT1 (UNIT1),
            .UNIT2 (UNIT2),
            .UNIT3 (UNIT3)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (rtc_tick),
            .sync_in   (pin_sync[i]),
            .count     (cfg_count[i*CNT_W +: CNT_W]),
            .unit_sel  (cfg_unit[i*2 +: 2]),
            .mode      (cfg_mode[i*2 +: 2]),
            .level_out (debounced[i])
        );
    end
endmodule

// File: rtl/debounce_bank_chk.sv
module debounce_bank_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS*2-1:0] cfg_mode,
    input logic [NUM_PINS-1:0]   pin_sync,
    input logic [NUM_PINS-1:0]   debounced
);
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (debounced == '0));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        a_r3_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode[i*2 +: 2] == 2'd0) |=> (debounced[i] == $past(pin_sync[i])));

        a_r7_low_passes: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode[i*2 +: 2] == 2'd1 && !pin_sync[i]) |=> !debounced[i]);

        a_r8_high_passes: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode[i*2 +: 2] == 2'd2 && pin_sync[i]) |=> debounced[i]);

        a_r5_rise_qualified: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(debounced[i]) && $past(cfg_mode[i*2 +: 2]) == 2'd3
                && $past(cfg_mode[i*2 +: 2], 2) == 2'd3)
            |-> ($past(pin_sync[i]) && $past(pin_sync[i], 2)));

        a_r5_fall_qualified: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(debounced[i]) && $past(cfg_mode[i*2 +: 2]) == 2'd3
                && $past(cfg_mode[i*2 +: 2], 2) == 2'd3)
            |-> (!$past(pin_sync[i]) && !$past(pin_sync[i], 2)));
    end
endmodule

bind debounce_bank debounce_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .pin_sync  (pin_sync),
    .debounced (debounced)
);

// File: tb/debounce_bank_bench.sv
`timescale 1ns/1ps
module debounce_bank_bench;
    localparam int NP = 4;
    localparam int CW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rtc_tick = 1'b1;
    logic [NP-1:0]    pin_raw = '0;
    logic [NP*CW-1:0] cfg_count = '0;
    logic [NP*2-1:0]  cfg_unit = '0;
    logic [NP*2-1:0]  cfg_mode = '0;
    logic [NP-1:0]    debounced;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    debounce_bank #(.NUM_PINS(NP), .CNT_W(CW)) u_debounce_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rtc_tick  (rtc_tick),
        .pin_raw   (pin_raw),
        .cfg_count (cfg_count),
        .cfg_unit  (cfg_unit),
        .cfg_mode  (cfg_mode),
        .debounced (debounced)
    );

    // {mode[15:14], unit[13:12], count[11:8], start[4], target[0]}
    localparam logic [15:0] VEC [12] = '{
        16'h0501, 16'h3F10, 16'hC101, 16'hD310, 16'hE101, 16'hF210,
        16'hC001, 16'h5210, 16'h5201, 16'h8401, 16'h8410, 16'hCF01
    };

    function automatic int unit_ticks(input logic [1:0] u);
        case (u)
            2'd0:    return 2;
            2'd1:    return 8;
            2'd2:    return 512;
            default: return 2048;
        endcase
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic cfg_pin(input int p, input logic [1:0] m, input logic [1:0] u,
                           input logic [CW-1:0] c);
        cfg_mode[p*2 +: 2]   = m;
        cfg_unit[p*2 +: 2]   = u;
        cfg_count[p*CW +: CW] = c;
    endtask

    // put pin 0 at a known level through bypass, then load the config
    task automatic settle(input logic lvl, input logic [1:0] m, input logic [1:0] u,
                          input logic [CW-1:0] c);
        cfg_pin(0, 2'd0, 2'd0, '0);
        pin_raw[0] = lvl;
        cyc(6);
        cfg_pin(0, m, u, c);
        cyc(3);
    endtask

    initial begin
        #50000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(3);
        check("R1 reset", debounced[0], 1'b0);
        check("R1 reset all", |debounced, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        check("R1 after release", |debounced, 1'b0);

        // table: R2 R3 R4 R5 R7 R8 R11
        for (int k = 0; k < 12; k++) begin
            logic [1:0] m;
            logic [1:0] u;
            logic [CW-1:0] c;
            logic st, tg, filt;
            int lat;
            m  = VEC[k][15:14];
            u  = VEC[k][13:12];
            c  = VEC[k][11:8];
            st = VEC[k][4];
            tg = VEC[k][0];
            filt = (m == 2'd3) || (m == 2'd1 && tg) || (m == 2'd2 && !tg);
            lat = filt ? (int'(c) * unit_ticks(u) + 4) : 3;
            settle(st, m, u, c);
            check($sformatf("R2/R5 row %0d start", k), debounced[0], st);
            pin_raw[0] = tg;
            cyc(lat - 1);
            check($sformatf("R4/R5/R7/R8/R11 row %0d before due", k), debounced[0], st);
            cyc(1);
            check($sformatf("R2/R3/R5/R11 row %0d at due", k), debounced[0], tg);
        end

        // R6: glitch shorter than 6 ticks rejected, then restart from zero
        settle(1'b0, 2'd3, 2'd0, 4'd3);
        pin_raw[0] = 1'b1;
        cyc(4);
        pin_raw[0] = 1'b0;
        cyc(15);
        check("R6 glitch rejected", debounced[0], 1'b0);
        pin_raw[0] = 1'b1;
        cyc(5);
        pin_raw[0] = 1'b0;
        cyc(1);
        pin_raw[0] = 1'b1;
        cyc(9);
        check("R6 restart before due", debounced[0], 1'b0);
        cyc(1);
        check("R6 restart at due", debounced[0], 1'b1);

        // R9: timer stalls without ticks
        settle(1'b0, 2'd3, 2'd0, 4'd1);
        rtc_tick = 1'b0;
        pin_raw[0] = 1'b1;
        cyc(20);
        check("R9 no tick holds", debounced[0], 1'b0);
        rtc_tick = 1'b1;
        cyc(2);
        check("R9 ticks resume before due", debounced[0], 1'b0);
        cyc(1);
        check("R9 ticks resume at due", debounced[0], 1'b1);

        // R10: reprogramming count mid-qualification restarts timing
        settle(1'b0, 2'd3, 2'd0, 4'd5);
        pin_raw[0] = 1'b1;
        cyc(8);
        cfg_count[0 +: CW] = 4'd4;
        cyc(4);
        check("R10 old progress discarded", debounced[0], 1'b0);
        cyc(6);
        check("R10 restart before due", debounced[0], 1'b0);
        cyc(1);
        check("R10 restart at due", debounced[0], 1'b1);

        // R12: independent lanes
        settle(1'b0, 2'd0, 2'd0, 4'd0);
        cfg_pin(1, 2'd3, 2'd3, 4'd15);
        cyc(2);
        pin_raw[1:0] = 2'b11;
        cyc(3);
        check("R12 bypass lane follows", debounced[0], 1'b1);
        check("R12 filtered lane holds", debounced[1], 1'b0);
        check("R12 idle lane untouched", debounced[2], 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule